// File: doc/BRIEF.md
# Sinc Decimation Accumulator Front-End

This block is the hardware half of a sinc-type decimation filter for a one-bit sigma-delta bitstream. A cascade of integrators runs on every enabled clock. At the end of each decimation period the block takes the value of the highest selected integrator, subtracts the value it held at the previous period end, and presents that difference as a wide sample. A one-cycle ready pulse marks each new sample.

Only the first comb (difference) stage is built here. Software reading the samples must apply the remaining differences itself: one more for second-order operation, two more for third-order operation. All arithmetic wraps modulo 2^32, so those later differences come out exact even when the integrators overflow. Any scaling shift is left to the consumer.

The period is a power of two, 2^N clocks, with N taken from a 4-bit setting and clamped to the range 3..13. Dropping the enable returns the whole filter to a clean starting point.

Top module: `sinc_decim_front`

## Requirements
- R1: After synchronous reset, `sample` is 0 and `sample_rdy` is 0.
- R2: On each enabled clock the three 32-bit integrators update together from their prior values: I1 += bit_in, I2 += I1, I3 += I2, all modulo 2^32.
- R3: `order_sel` = 1 selects I3 (third order) as the differentiated integrator; `order_sel` = 0 selects I2 (second order).
- R4: A period ends on the 2^N-th enabled clock counted from enable or from the previous period end. In the cycle after that clock, `sample_rdy` is 1.
- R5: At a period end, `sample` becomes the selected integrator's value after that clock's update, minus the value stored at the previous period end (0 for the first period after enable), modulo 2^32. With all-ones input and N=3, the first two third-order samples are 56 and 504, and the first second-order sample is 28.
- R6: `sample_rdy` is high for exactly one cycle, and `sample` holds its value until the next period end.
- R7: While `en` is 0, the integrators, the period counter and the stored previous value are cleared, and `sample_rdy` stays 0. `sample` keeps its last value.
- R8: Samples stay correct after the integrators wrap past 2^32. For all-ones third-order input, the k-th sample equals T(kP) - T((k-1)P) mod 2^32, where T(m) = m(m-1)(m-2)/6.
- R9: A `dec_log2` value below 3 behaves as 3 (8 clocks), and a value above 13 behaves as 13 (8192 clocks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low clears the filter state |
| bit_in | input | 1 | Modulator bitstream bit |
| order_sel | input | 1 | 1 = third order, 0 = second order |
| dec_log2 | input | 4 | Period exponent N; period is 2^N clocks, clamped to 3..13 |
| sample | output | 32 | First-difference sample word |
| sample_rdy | output | 1 | One-cycle pulse when a new sample is latched |

## Verification
The hardest condition to reach from the ports is the third integrator wrapping past 2^32 while the samples remain exact. Random data rarely drives it there within a short run. The stimulus therefore feeds a long run of all-ones input at a 1024-clock period, which overflows the third integrator within about three thousand clocks. Each sample is then compared against a closed-form cubic computed in 64-bit arithmetic. The longest period and the clamping of out-of-range exponents are reached by directed runs that count the clocks between ready pulses.

// File: rtl/sinc_pkg.sv
package sinc_pkg;

    localparam int ACC_W    = 32;
    localparam int STAGES   = 3;
    localparam int MIN_LOG2 = 3;
    localparam int MAX_LOG2 = 13;
    localparam int CNT_W    = MAX_LOG2;
    localparam int SEL_W    = 4;

    typedef logic [ACC_W-1:0] acc_t;

    typedef enum logic {
        ORD_SECOND = 1'b0,
        ORD_THIRD  = 1'b1
    } order_e;

    typedef struct packed {
        acc_t value;
        logic ready;
    } sample_t;

    // Terminal count (2^N - 1) for a requested exponent, clamped to the legal range.
    function automatic logic [CNT_W-1:0] period_limit(input logic [SEL_W-1:0] sel);
        logic [SEL_W-1:0] k;
        if (sel < SEL_W'(MIN_LOG2))
            k = SEL_W'(MIN_LOG2);
        else if (sel > SEL_W'(MAX_LOG2))
            k = SEL_W'(MAX_LOG2);
        else
            k = sel;
        return CNT_W'((32'd1 << k) - 32'd1);
    endfunction

endpackage

// File: rtl/sinc_integ.sv
module sinc_integ #(
    parameter int W = sinc_pkg::ACC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] in_v,
    output logic [W-1:0] acc_q,
    output logic [W-1:0] acc_d
);
    // Wrapping sum; the overflow is intentional.
    always_comb acc_d = acc_q + in_v;

    always_ff @(posedge clk) begin
        if (rst || !run)
            acc_q <= '0;
        else
            acc_q <= acc_d;
    end
endmodule

// File: rtl/sinc_timer.sv
module sinc_timer #(
    parameter int CW    = sinc_pkg::CNT_W,
    parameter int SEL_W = sinc_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] dec_sel,
    output logic             period_end
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit      = CW'(sinc_pkg::period_limit(dec_sel));
        period_end = run && (cnt_q >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (period_end)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sinc_comb.sv
module sinc_comb #(
    parameter int W = sinc_pkg::ACC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         period_end,
    input  logic [W-1:0] top_d,
    output logic [W-1:0] sample_o,
    output logic         ready_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            sample_o <= '0;
            ready_o  <= 1'b0;
        end else if (!run) begin
            prev_q  <= '0;
            ready_o <= 1'b0;
        end else begin
            ready_o <= period_end;
            if (period_end) begin
                sample_o <= top_d - prev_q;
                prev_q   <= top_d;
            end
        end
    end
endmodule

// File: rtl/sinc_decim_front.sv
module sinc_decim_front
    import sinc_pkg::*;
#(
    parameter int ACC_BITS = sinc_pkg::ACC_W,
    parameter int N_STAGES = sinc_pkg::STAGES,
    parameter int DSEL_W   = sinc_pkg::SEL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                bit_in,
    input  logic                order_sel,
    input  logic [DSEL_W-1:0]   dec_log2,
    output logic [ACC_BITS-1:0] sample,
    output logic                sample_rdy
);
    localparam int TOP_HI = N_STAGES - 1;
    localparam int TOP_LO = N_STAGES - 2;

    logic [ACC_BITS-1:0] acc_q [N_STAGES];
    logic [ACC_BITS-1:0] acc_d [N_STAGES];
    logic [ACC_BITS-1:0] top_d;
    logic                period_end;
    order_e              order;
    sample_t             smp;

    genvar gi;
    generate
        for (gi = 0; gi < N_STAGES; gi++) begin : g_stage
            logic [ACC_BITS-1:0] feed;
            if (gi == 0) begin : g_first
                always_comb feed = ACC_BITS'(bit_in);
            end else begin : g_next
                always_comb feed = acc_q[gi-1];
            end
            sinc_integ #(.W(ACC_BITS)) u_integ (
                .clk   (clk),
                .rst   (rst),
                .run   (en),
                .in_v  (feed),
                .acc_q (acc_q[gi]),
                .acc_d (acc_d[gi])
            );
        end
    endgenerate

    always_comb begin
        order = order_e'(order_sel);
        top_d = (order == ORD_THIRD) ? acc_d[TOP_HI] : acc_d[TOP_LO];
    end

    sinc_timer #(.CW(sinc_pkg::CNT_W), .SEL_W(DSEL_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .run        (en),
        .dec_sel    (dec_log2),
        .period_end (period_end)
    );

    sinc_comb #(.W(ACC_BITS)) u_comb (
        .clk        (clk),
        .rst        (rst),
        .run        (en),
        .period_end (period_end),
        .top_d      (top_d),
        .sample_o   (smp.value),
        .ready_o    (smp.ready)
    );

    always_comb begin
        sample     = smp.value;
        sample_rdy = smp.ready;
    end
endmodule

// File: rtl/sinc_decim_front_chk.sv
module sinc_decim_front_chk #(
    parameter int ACC_BITS = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                en,
    input logic [ACC_BITS-1:0] sample,
    input logic                sample_rdy
);
    // R6
    rdy_single_chk: assert property (@(posedge clk) disable iff (rst)
        sample_rdy |=> !sample_rdy);

    // R6
    sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_rdy |-> $stable(sample));

    // R7
    idle_no_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !sample_rdy);

    // R4
    rdy_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        sample_rdy |-> $past(en));

    // R7
    idle_keeps_sample_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(sample));
endmodule

bind sinc_decim_front sinc_decim_front_chk #(.ACC_BITS(ACC_BITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .sample     (sample),
    .sample_rdy (sample_rdy)
);

// File: tb/sinc_decim_front_test.sv
`timescale 1ns/1ps
module sinc_decim_front_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        bit_in = 1'b0;
    logic        order_sel = 1'b1;
    logic [3:0]  dec_log2 = 4'd3;
    logic [31:0] sample;
    logic        sample_rdy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string tag = "R2";

    // bench reference state
    logic [31:0] m1 = 0, m2 = 0, m3 = 0, mprev = 0, exp_sample = 0;
    int          mcnt = 0;
    logic        exp_rdy = 1'b0;

    always #2.5 clk = ~clk;

    sinc_decim_front uut (
        .clk(clk), .rst(rst), .en(en), .bit_in(bit_in),
        .order_sel(order_sel), .dec_log2(dec_log2),
        .sample(sample), .sample_rdy(sample_rdy)
    );

    function automatic int lim_of(input logic [3:0] n);
        int k;
        k = (n < 3) ? 3 : (n > 13) ? 13 : int'(n);
        return (1 << k) - 1;
    endfunction

    function automatic logic [31:0] cubic(input longint m);
        longint v;
        if (m < 3) return 32'd0;
        v = (m * (m - 1) * (m - 2)) / 6;
        return v[31:0];
    endfunction

    task automatic check(input bit ok, input string t, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", t, act, expv);
        end
    endtask

    // Drive one clock worth of input (called at a negedge), advance the model,
    // then compare after the edge at the following negedge.
    task automatic tick(input logic b);
        logic [31:0] n1, n2, n3, top;
        bit_in = b;
        if (rst) begin
            m1 = 0; m2 = 0; m3 = 0; mprev = 0; mcnt = 0; exp_sample = 0; exp_rdy = 0;
        end else if (!en) begin
            m1 = 0; m2 = 0; m3 = 0; mprev = 0; mcnt = 0; exp_rdy = 0;
        end else begin
            n1 = m1 + {31'd0, b};
            n2 = m2 + m1;
            n3 = m3 + m2;
            top = order_sel ? n3 : n2;
            if (mcnt >= lim_of(dec_log2)) begin
                exp_sample = top - mprev;
                mprev = top;
                exp_rdy = 1'b1;
                mcnt = 0;
            end else begin
                exp_rdy = 1'b0;
                mcnt++;
            end
            m1 = n1; m2 = n2; m3 = n3;
        end
        @(posedge clk);
        @(negedge clk);
        check(sample_rdy === exp_rdy, {tag, " ready"}, {31'd0, sample_rdy}, {31'd0, exp_rdy});
        check(sample === exp_sample, {tag, " sample"}, sample, exp_sample);
    endtask

    task automatic ticks_until_rdy(input logic b, input int maxn, output int n);
        n = 0;
        do begin
            tick(b);
            n++;
        end while (!sample_rdy && n < maxn);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n;
        int k;
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1 reset state
        tag = "R1";
        repeat (3) tick(1'b1);
        check(sample === 32'd0, "R1 reset sample", sample, 0);
        check(sample_rdy === 1'b0, "R1 reset ready", {31'd0, sample_rdy}, 0);
        rst = 1'b0;

        // R5 directed third order, N=3, all ones
        tag = "R5"; en = 1'b1; order_sel = 1'b1; dec_log2 = 4'd3;
        repeat (8) tick(1'b1);
        check(sample_rdy === 1'b1, "R5 first pulse", {31'd0, sample_rdy}, 1);
        check(sample === 32'd56, "R5 first third-order sample", sample, 56);
        repeat (8) tick(1'b1);
        check(sample === 32'd504, "R5 second third-order sample", sample, 504);

        // R6 hold between pulses
        tag = "R6";
        tick(1'b0);
        check(sample === 32'd504 && !sample_rdy, "R6 hold after pulse", sample, 504);

        // R7 disable clears state, keeps output
        tag = "R7"; en = 1'b0;
        repeat (4) tick(1'b1);
        check(sample === 32'd504, "R7 sample kept while idle", sample, 504);

        // R3 second order after re-enable (previous value cleared)
        tag = "R3"; en = 1'b1; order_sel = 1'b0;
        repeat (8) tick(1'b1);
        check(sample === 32'd28, "R3 second-order first sample", sample, 28);

        // R9 clamp low and high
        tag = "R9"; en = 1'b0; tick(1'b0);
        en = 1'b1; dec_log2 = 4'd0;
        ticks_until_rdy(1'b1, 20, n);
        check(n == 8, "R9 low clamp period", n, 8);
        en = 1'b0; tick(1'b0);
        en = 1'b1; dec_log2 = 4'd15;
        ticks_until_rdy(1'b0, 9000, n);
        check(n == 8192, "R9 high clamp period", n, 8192);
        // R4 nominal period 2^5
        tag = "R4"; en = 1'b0; tick(1'b0);
        en = 1'b1; dec_log2 = 4'd5;
        ticks_until_rdy(1'b1, 100, n);
        check(n == 32, "R4 period 2^5", n, 32);
        ticks_until_rdy(1'b0, 100, n);
        check(n == 32, "R4 second period 2^5", n, 32);

        // R8 long all-ones third-order run, integrator wraps
        tag = "R8"; en = 1'b0; tick(1'b0);
        en = 1'b1; order_sel = 1'b1; dec_log2 = 4'd10;
        for (int p = 1; p <= 6; p++) begin
            ticks_until_rdy(1'b1, 2000, n);
            check(sample === cubic(longint'(p) * 1024) - cubic(longint'(p - 1) * 1024),
                  "R8 wrapped sample", sample,
                  cubic(longint'(p) * 1024) - cubic(longint'(p - 1) * 1024));
        end

        // R2 random segments
        tag = "R2";
        for (int s = 0; s < 24; s++) begin
            en = 1'b0; tick(1'b0);
            en = 1'b1;
            order_sel = $urandom_range(1, 0) != 0;
            dec_log2 = 4'($urandom_range(8, 2));
            k = $urandom_range(3, 0);
            for (int c = 0; c < int'($urandom_range(1500, 600)); c++) begin
                if ($urandom_range(199, 0) == 0) en = ~en;
                tick(($urandom_range(3, 0) < k) ? 1'b1 : 1'b0);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule